// File: doc/BRIEF.md
# Serial Booth-Recoded Modular Multiplier

This block multiplies two unsigned binary residues, `a_in` and `b_in`, of `P` bits each. The product is taken modulo 2^P−1 or 2^P+1, and `mod_plus` chooses which. The result is a `P`-digit radix-two signed-digit word. Each digit is carried on two wires, `prod_pos[i]` and `prod_neg[i]`, and the word stands for Σ(prod_pos[i] − prod_neg[i])·2^i. It needs only to be congruent to the true product; turning it into canonical binary is left to downstream logic.

The multiplier `b_in` is split into radix-4 Booth digits with values in {−2, −1, 0, +1, +2}. Digit i is formed as d_i = −2·b[2i+1] + b[2i] + b[2i−1], where b[−1] = 0 and every bit above P−1 is zero. That gives ND = P/2+1 digits, using integer division. Each cycle, two recoder lanes each take one digit and build its partial product A·d_i·4^i. They do this by rotating the multiplicand left 2i places, plus one more place when |d_i| = 2, and then flipping the sign of every digit if d_i < 0. The rotation works because 2^P ≡ ±1 under the modulus. For the 2^P+1 modulus, each bit negates every time it wraps past position P−1. Both partial products are folded into the accumulator in the same cycle by a carry-free three-operand modular signed-digit adder. One run therefore takes STEPS = ceil(ND/2) cycles, which is 3 for P = 8.

The control is a three-state machine:
- IDLE waits. The GO transition, taken when `start` is high, captures the operands and the modulus, clears the accumulator and enters RUN.
- RUN adds one pair of partial products per cycle. It loops on itself (STEP) and takes FINISH to DONE after the last pair.
- DONE raises `done` for exactly one cycle. It then takes RETIRE back to IDLE, and the result is held there.

Top module: `smd_mult`

## Requirements
- R1: After reset, `busy` and `done` are 0 and every product digit wire is 0.
- R2: A `start` sampled high in IDLE makes `busy` high on the next cycle. The operands and `mod_plus` are captured at that edge.
- R3: `busy` stays high for exactly STEPS = ceil((P/2+1)/2) cycles, because two Booth digits are consumed per cycle. `done` is then high for exactly one cycle, during which `busy` is low.
- R4: With `mod_plus` = 0, the product value Σ(prod_pos[i] − prod_neg[i])·2^i is congruent to a_in·b_in modulo 2^P−1.
- R5: With `mod_plus` = 1, the product value is congruent to a_in·b_in modulo 2^P+1. Here a partial-product bit that wraps past position P−1 changes sign.
- R6: No product digit ever has both `prod_pos[i]` and `prod_neg[i]` set. Each digit is one of +1 (1,0), 0 (0,0) or −1 (0,1).
- R7: From `done` until the next accepted `start`, the product outputs stay unchanged.
- R8: A `start` pulse while `busy` is high is ignored. The run keeps its length, and its result belongs to the first operands.
- R9: Changes on `a_in`, `b_in` or `mod_plus` after the capturing edge have no effect on the running product.
- R10: A zero multiplicand or multiplier gives a product congruent to 0, under either modulus.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a multiplication when idle |
| mod_plus | input | 1 | 0: modulus 2^P−1, 1: modulus 2^P+1 |
| a_in | input | P | Multiplicand, unsigned |
| b_in | input | P | Multiplier, unsigned, Booth recoded |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle completion pulse |
| prod_pos | output | P | Positive halves of the product digits |
| prod_neg | output | P | Negative halves of the product digits |

## Verification
The bench goes after the operand extremes: all ones, zero, and alternating bit patterns. A design that rotates wrapped bits without negating them under 2^P+1 would give a wrong residue for those operands. So would one that mishandles the top Booth digit, which comes from bits above the operand and yields +1 for an all-ones multiplier. An off-by-one in the step counter would show as a run one cycle too short or too long, and as a lost or duplicated pair of partial products. A mid-run `start` pulse together with changed operand inputs exposes a design that restarts or re-samples its operands: the residue would then match neither the original nor the new pair. Holding the outputs for several cycles after `done` catches an accumulator that keeps adding once the run has ended.

// File: rtl/smd_pkg.sv
package smd_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } smd_state_t;

    // value of one signed digit held as a (pos, neg) pair
    function automatic logic signed [2:0] sd_val(input logic p, input logic n);
        return $signed({2'b00, p}) - $signed({2'b00, n});
    endfunction

endpackage

// File: rtl/smd_booth_rec.sv
// Radix-4 Booth recoder: triple {b[2i+1], b[2i], b[2i-1]} -> digit
module smd_booth_rec (
    input  logic [2:0] trip,
    output logic       is_zero,
    output logic       is_neg,
    output logic       is_dbl
);
    always_comb begin
        is_zero = 1'b0;
        is_neg  = 1'b0;
        is_dbl  = 1'b0;
        unique case (trip)
            3'b000, 3'b111: is_zero = 1'b1;
            3'b001, 3'b010: ;
            3'b011:         is_dbl  = 1'b1;
            3'b100: begin
                is_neg = 1'b1;
                is_dbl = 1'b1;
            end
            3'b101, 3'b110: is_neg  = 1'b1;
            default:        is_zero = 1'b1;
        endcase
    end
endmodule

// File: rtl/smd_pp_gen.sv
// Modular partial product: rotate the multiplicand by shamt places.
// For the 2^P+1 modulus each wrap past the top negates the bit.
module smd_pp_gen #(
    parameter int P   = 8,
    parameter int SHW = 4
) (
    input  logic [P-1:0]   a_val,
    input  logic           plus,
    input  logic [SHW-1:0] shamt,
    input  logic           is_zero,
    input  logic           is_neg,
    output logic [P-1:0]   pp_pos,
    output logic [P-1:0]   pp_neg
);
    always_comb begin
        pp_pos = '0;
        pp_neg = '0;
        for (int j = 0; j < P; j++) begin
            int   tot;
            int   dst;
            logic flip;
            tot  = j + int'(shamt);
            dst  = tot % P;
            flip = (plus && (((tot / P) % 2) == 1)) ^ is_neg;
            if (!is_zero && a_val[j]) begin
                if (flip) pp_neg[dst] = 1'b1;
                else      pp_pos[dst] = 1'b1;
            end
        end
    end
endmodule

// File: rtl/smd_sd_add2.sv
// Carry-free modular two-operand signed-digit adder.
// The transfer out of the top digit re-enters digit 0 (negated for 2^P+1).
module smd_sd_add2 #(
    parameter int P = 8
) (
    input  logic         plus,
    input  logic [P-1:0] x_pos,
    input  logic [P-1:0] x_neg,
    input  logic [P-1:0] y_pos,
    input  logic [P-1:0] y_neg,
    output logic [P-1:0] s_pos,
    output logic [P-1:0] s_neg
);
    import smd_pkg::*;

    logic signed [2:0] xd [P];
    logic signed [2:0] yd [P];
    logic signed [2:0] tv [P];
    logic signed [2:0] wv [P];

    always_comb begin
        for (int i = 0; i < P; i++) begin
            xd[i] = sd_val(x_pos[i], x_neg[i]);
            yd[i] = sd_val(y_pos[i], y_neg[i]);
        end
    end

    // interim digit and transfer, chosen from this position and the one below
    always_comb begin
        for (int i = 0; i < P; i++) begin
            logic signed [2:0] xl;
            logic signed [2:0] yl;
            logic signed [2:0] z;
            logic              nn;
            if (i == 0) begin
                xl = plus ? -xd[P-1] : xd[P-1];
                yl = plus ? -yd[P-1] : yd[P-1];
            end else begin
                xl = xd[i-1];
                yl = yd[i-1];
            end
            nn = (xl >= 3'sd0) && (yl >= 3'sd0);
            z  = xd[i] + yd[i];
            if (z == 3'sd2) begin
                tv[i] = 3'sd1;
                wv[i] = 3'sd0;
            end else if (z == -3'sd2) begin
                tv[i] = -3'sd1;
                wv[i] = 3'sd0;
            end else if (z == 3'sd1) begin
                tv[i] = nn ? 3'sd1 : 3'sd0;
                wv[i] = nn ? -3'sd1 : 3'sd1;
            end else if (z == -3'sd1) begin
                tv[i] = nn ? 3'sd0 : -3'sd1;
                wv[i] = nn ? -3'sd1 : 3'sd1;
            end else begin
                tv[i] = 3'sd0;
                wv[i] = 3'sd0;
            end
        end
    end

    always_comb begin
        for (int i = 0; i < P; i++) begin
            logic signed [2:0] tin;
            logic signed [2:0] s;
            if (i == 0) tin = plus ? -tv[P-1] : tv[P-1];
            else        tin = tv[i-1];
            s        = wv[i] + tin;
            s_pos[i] = (s == 3'sd1);
            s_neg[i] = (s == -3'sd1);
        end
    end
endmodule

// File: rtl/smd_sd_add3.sv
// Three-operand modular signed-digit adder: two carry-free stages, fixed depth
module smd_sd_add3 #(
    parameter int P = 8
) (
    input  logic         plus,
    input  logic [P-1:0] acc_pos,
    input  logic [P-1:0] acc_neg,
    input  logic [P-1:0] p0_pos,
    input  logic [P-1:0] p0_neg,
    input  logic [P-1:0] p1_pos,
    input  logic [P-1:0] p1_neg,
    output logic [P-1:0] sum_pos,
    output logic [P-1:0] sum_neg
);
    logic [P-1:0] mid_pos;
    logic [P-1:0] mid_neg;

    smd_sd_add2 #(.P(P)) u_stage0 (
        .plus  (plus),
        .x_pos (acc_pos),
        .x_neg (acc_neg),
        .y_pos (p0_pos),
        .y_neg (p0_neg),
        .s_pos (mid_pos),
        .s_neg (mid_neg)
    );

    smd_sd_add2 #(.P(P)) u_stage1 (
        .plus  (plus),
        .x_pos (mid_pos),
        .x_neg (mid_neg),
        .y_pos (p1_pos),
        .y_neg (p1_neg),
        .s_pos (sum_pos),
        .s_neg (sum_neg)
    );
endmodule

// File: rtl/smd_mult.sv
module smd_mult #(
    parameter int P = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic         mod_plus,
    input  logic [P-1:0] a_in,
    input  logic [P-1:0] b_in,
    output logic         busy,
    output logic         done,
    output logic [P-1:0] prod_pos,
    output logic [P-1:0] prod_neg
);
    import smd_pkg::*;

    localparam int ND    = P / 2 + 1;               // Booth digits
    localparam int STEPS = (ND + 1) / 2;            // two digits per cycle
    localparam int BXW   = 4 * STEPS + 1;           // padded multiplier
    localparam int SHW   = $clog2(4 * STEPS);       // rotate amount width
    localparam int CW    = (STEPS > 1) ? $clog2(STEPS) : 1;

    smd_state_t state_q;
    smd_state_t state_d;

    logic [P-1:0]   a_q;
    logic [BXW-1:0] bx_q;
    logic           plus_q;
    logic [CW-1:0]  step_q;
    logic [P-1:0]   acc_pos_q;
    logic [P-1:0]   acc_neg_q;
    logic           last_step;

    logic [P-1:0] lane_pos [2];
    logic [P-1:0] lane_neg [2];
    logic [P-1:0] sum_pos;
    logic [P-1:0] sum_neg;

    assign last_step = (step_q == CW'(STEPS - 1));

    // two recoder / partial-product lanes
    for (genvar g = 0; g < 2; g++) begin : g_lane
        logic [SHW-1:0] base;
        logic [2:0]     trip;
        logic           dz;
        logic           dn;
        logic           dd;
        logic [SHW-1:0] shamt;

        assign base  = SHW'({step_q, 2'b00}) + SHW'(2 * g);
        assign trip  = 3'(bx_q >> base);
        assign shamt = base + SHW'(dd);

        smd_booth_rec u_rec (
            .trip    (trip),
            .is_zero (dz),
            .is_neg  (dn),
            .is_dbl  (dd)
        );

        smd_pp_gen #(.P(P), .SHW(SHW)) u_pp (
            .a_val   (a_q),
            .plus    (plus_q),
            .shamt   (shamt),
            .is_zero (dz),
            .is_neg  (dn),
            .pp_pos  (lane_pos[g]),
            .pp_neg  (lane_neg[g])
        );
    end

    smd_sd_add3 #(.P(P)) u_add3 (
        .plus    (plus_q),
        .acc_pos (acc_pos_q),
        .acc_neg (acc_neg_q),
        .p0_pos  (lane_pos[0]),
        .p0_neg  (lane_neg[0]),
        .p1_pos  (lane_pos[1]),
        .p1_neg  (lane_neg[1]),
        .sum_pos (sum_pos),
        .sum_neg (sum_neg)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions: GO, STEP, FINISH, RETIRE
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start) state_d = ST_RUN;
            ST_RUN:  if (last_step) state_d = ST_DONE;
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            a_q       <= '0;
            bx_q      <= '0;
            plus_q    <= 1'b0;
            step_q    <= '0;
            acc_pos_q <= '0;
            acc_neg_q <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        a_q       <= a_in;
                        bx_q      <= BXW'({b_in, 1'b0});
                        plus_q    <= mod_plus;
                        step_q    <= '0;
                        acc_pos_q <= '0;
                        acc_neg_q <= '0;
                    end
                end
                ST_RUN: begin
                    acc_pos_q <= sum_pos;
                    acc_neg_q <= sum_neg;
                    step_q    <= step_q + CW'(1);
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        busy     = (state_q == ST_RUN);
        done     = (state_q == ST_DONE);
        prod_pos = acc_pos_q;
        prod_neg = acc_neg_q;
    end
endmodule

// File: rtl/smd_mult_chk.sv
module smd_mult_chk #(
    parameter int P = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         start,
    input logic         busy,
    input logic         done,
    input logic [P-1:0] prod_pos,
    input logic [P-1:0] prod_neg
);
    localparam int ND    = P / 2 + 1;
    localparam int STEPS = (ND + 1) / 2;

    int run_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    run_cnt <= 0;
        else if (busy) run_cnt <= run_cnt + 1;
        else           run_cnt <= 0;
    end

    AST_GO_TO_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && !done) |=> busy); // R2

    AST_RUN_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (done && run_cnt == STEPS)); // R3

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R3

    AST_BUSY_DONE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done)); // R3

    AST_DIGIT_CANON: assert property (@(posedge clk) disable iff (!rst_n)
        (prod_pos & prod_neg) == '0); // R6

    AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> ($stable(prod_pos) && $stable(prod_neg))); // R7

    AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && run_cnt < STEPS - 1) |=> busy); // R8
endmodule

bind smd_mult smd_mult_chk #(.P(P)) u_smd_mult_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .busy     (busy),
    .done     (done),
    .prod_pos (prod_pos),
    .prod_neg (prod_neg)
);

// File: tb/test_smd_mult.sv
module test_smd_mult;
    localparam int  P      = 8;
    localparam int  ND     = P / 2 + 1;
    localparam int  STEPS  = (ND + 1) / 2;
    localparam time T_CLK  = 10ns;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic         mod_plus = 1'b0;
    logic [P-1:0] a_in = '0;
    logic [P-1:0] b_in = '0;
    logic         busy;
    logic         done;
    logic [P-1:0] prod_pos;
    logic [P-1:0] prod_neg;

    int checks = 0;
    int errors = 0;

    always #(T_CLK / 2) clk = ~clk;

    smd_mult #(.P(P)) i_smd_mult (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .mod_plus (mod_plus),
        .a_in     (a_in),
        .b_in     (b_in),
        .busy     (busy),
        .done     (done),
        .prod_pos (prod_pos),
        .prod_neg (prod_neg)
    );

    function automatic longint modulus(input bit plus);
        return plus ? (longint'(1) << P) + 1 : (longint'(1) << P) - 1;
    endfunction

    function automatic longint ref_prod(input longint a, input longint b, input bit plus);
        return (a * b) % modulus(plus);
    endfunction

    function automatic longint sd_residue(input logic [P-1:0] pp, input logic [P-1:0] nn,
                                          input bit plus);
        longint v;
        longint m;
        m = modulus(plus);
        v = longint'(pp) - longint'(nn);
        return ((v % m) + m) % m;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // one multiplication; disturb pulses start and changes operands mid-run
    task automatic do_run(input logic [P-1:0] a, input logic [P-1:0] b,
                          input bit plus, input bit disturb, input string tag);
        int           n;
        longint       got;
        longint       exp;
        logic [P-1:0] hp;
        logic [P-1:0] hn;
        @(negedge clk);
        a_in = a; b_in = b; mod_plus = plus; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (disturb) begin
            a_in = ~a; b_in = b ^ 8'h5a; mod_plus = ~plus;
        end
        check(busy == 1'b1, "R2", "busy after start", longint'(busy), 1);
        n = 0;
        while (busy && n < 4 * STEPS + 4) begin
            n++;
            if (disturb && n == 1) start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        check(n == STEPS, disturb ? "R8" : "R3", "busy cycles", n, STEPS);
        check(done == 1'b1, "R3", "done after run", longint'(done), 1);
        check((prod_pos & prod_neg) == '0, "R6", "digit canon",
              longint'(prod_pos & prod_neg), 0);
        got = sd_residue(prod_pos, prod_neg, plus);
        exp = ref_prod(longint'(a), longint'(b), plus);
        check(got == exp, tag, $sformatf("residue a=%0d b=%0d plus=%0d", a, b, plus), got, exp);
        hp = prod_pos; hn = prod_neg;
        @(negedge clk);
        check(done == 1'b0, "R3", "done single cycle", longint'(done), 0);
        repeat (3) @(negedge clk);
        check(prod_pos == hp && prod_neg == hn, "R7", "held result pos",
              longint'(prod_pos), longint'(hp));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [P-1:0] ra;
        logic [P-1:0] rb;
        void'($urandom(32'h1bad5eed));
        repeat (3) @(negedge clk);
        // R1: reset state
        check(busy == 1'b0, "R1", "busy in reset", longint'(busy), 0);
        check(done == 1'b0, "R1", "done in reset", longint'(done), 0);
        check(prod_pos == '0 && prod_neg == '0, "R1", "product in reset",
              longint'(prod_pos | prod_neg), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        for (int m = 0; m < 2; m++) begin
            string t;
            t = (m == 1) ? "R5" : "R4";
            do_run(8'h00, 8'hb7, bit'(m), 1'b0, "R10");
            do_run(8'h93, 8'h00, bit'(m), 1'b0, "R10");
            do_run(8'hff, 8'hff, bit'(m), 1'b0, t);
            do_run(8'hfe, 8'hff, bit'(m), 1'b0, t);
            do_run(8'h01, 8'h01, bit'(m), 1'b0, t);
            do_run(8'h55, 8'haa, bit'(m), 1'b0, t);
            do_run(8'h80, 8'h80, bit'(m), 1'b0, t);
            do_run(8'hc3, 8'h7e, bit'(m), 1'b1, "R9");
            for (int k = 0; k < 40; k++) begin
                ra = P'($urandom());
                rb = P'($urandom());
                do_run(ra, rb, bit'(m), 1'b0, t);
            end
        end
        // start pulse while busy, mixed modulus
        do_run(8'h6d, 8'hf1, 1'b1, 1'b1, "R8");
        do_run(8'h39, 8'h2c, 1'b0, 1'b1, "R8");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule